// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the master side of a link to a 12-bit serial sampling converter. It drives the active-low chip select and the serial clock, and it samples the converter's data line. Lowering chip select starts a conversion. The block then clocks one 16-bit frame. That frame is four leading bits, which must be zero, followed by twelve result bits sent most significant bit first. The block presents the result with a one-cycle valid strobe. If any leading bit was set, it also raises a framing-error flag in the same cycle.

All serial timing is counted in system clock cycles. These are the serial clock half period, the chip-select-to-clock setup, the quiet gap after a frame, and the throughput period from one chip-select fall to the next. If the throughput period is too short to hold a whole frame plus the quiet gap, it is rounded up so that every interval still meets its minimum. In free-run mode a frame starts as soon as the period allows. In single-shot mode a frame starts only on a start pulse that arrives while the block is idle and the period has run out.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is asserted and after it is released with no frame requested, `cs_no` is 1, `sclk_o` is 1 and `valid_o` is 0.
- R2: After `cs_no` falls, `sclk_o` stays high for exactly `CS_SETUP_CYC` system cycles before its first falling edge.
- R3: A frame carries exactly 16 serial clock periods, each made of `SCLK_HALF_CYC` cycles low followed by `SCLK_HALF_CYC` cycles high. `sclk_o` idles high and changes only while `cs_no` is 0.
- R4: `sdata_i` is sampled on each rising edge of `sclk_o`. The first 4 samples are the leading bits. The next 12 samples form `result_o`, with the first of them as bit 11 and the last as bit 0.
- R5: `cs_no` rises `SCLK_HALF_CYC` cycles after the 16th rising edge of `sclk_o`. `valid_o` is high for that one cycle only, and `result_o` holds its value until the next frame completes.
- R6: `frame_err_o` is 1 in the `valid_o` cycle exactly when at least one of the 4 leading samples was 1. It is 0 in every other cycle.
- R7: After `cs_no` rises, it stays high for at least `QUIET_CYC` + 1 cycles before it may fall again.
- R8: With `free_run_i` held at 1, successive falls of `cs_no` are exactly max(`PERIOD_CYC`, `CS_SETUP_CYC` + 32·`SCLK_HALF_CYC` + `QUIET_CYC` + 1) cycles apart.
- R9: With `free_run_i` at 0, a frame starts only on a clock edge where `start_i` is 1, the block is idle and the throughput period since the last frame start has elapsed. A `start_i` pulse at any other time is ignored, and no frame starts without a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| free_run_i | input | 1 | 1: convert continuously at the throughput period |
| start_i | input | 1 | Single-shot frame request, used when free_run_i is 0 |
| sdata_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| result_o | output | 12 | Last assembled result |
| valid_o | output | 1 | One-cycle strobe: result_o updated |
| frame_err_o | output | 1 | Leading bits of this frame were not all zero |

## Verification
A wrong phase, half-period or bit counter shows at the pins within one serial half period. `sclk_o` then toggles a cycle early or late, or a sixteenth pulse is missing or extra, and `cs_no` rises off schedule. A fault in the throughput or quiet counters first appears on the next expected chip-select fall, so it can take up to one frame period to show. A fault in the shift path or the split between leading bits and data bits appears only in the valid cycle, as a wrong `result_o` or `frame_err_o`. For that reason the frame patterns use all-ones, all-zeros, alternating data and nonzero leading nibbles.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_QUIET
  } rd_state_e;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rate_gate.sv
module adc_rate_gate #(
  parameter int unsigned PERIOD_CYC = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic launch_i,
  output logic ready_o
);
  localparam int unsigned PW   = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD_CYC - 1);

  logic [PW-1:0] per_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              per_cnt <= LAST;
    else if (launch_i)        per_cnt <= '0;
    else if (per_cnt != LAST) per_cnt <= per_cnt + 1'b1;
  end

  assign ready_o = (per_cnt == LAST);

  // period of at least two cycles: a launch is never followed by another at once
  p_no_back_to_back_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> !ready_o);

endmodule

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,   // drop sclk now, first low half begins
  input  logic en_i,     // frame in progress
  input  logic hold_i,   // last bit: keep sclk high at end of its high half
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [HW-1:0] HLAST = HW'(HALF_CYC - 1);

  logic [HW-1:0] hcnt;
  logic          sclk_q;
  logic          half_end;

  assign half_end = (hcnt == HLAST);
  assign rise_o   = en_i & half_end & ~sclk_q;
  assign fall_o   = en_i & half_end & sclk_q;
  assign sclk_o   = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      hcnt   <= '0;
    end else if (load_i) begin
      sclk_q <= 1'b0;
      hcnt   <= '0;
    end else if (en_i) begin
      if (half_end) begin
        hcnt <= '0;
        if (!sclk_q || !hold_i) sclk_q <= ~sclk_q;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end else begin
      sclk_q <= 1'b1;
      hcnt   <= '0;
    end
  end

  p_fall_source_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> ($past(load_i) || $past(fall_o)));

  p_rise_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> sclk_o);

endmodule

// File: rtl/adc_shift_capture.sv
module adc_shift_capture #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             sdata_i,
  output logic [WIDTH-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (shift_i) word_o <= {word_o[WIDTH-2:0], sdata_i};
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_frame_pkg::*;
#(
  parameter int unsigned SCLK_HALF_CYC = 2,
  parameter int unsigned CS_SETUP_CYC  = 2,
  parameter int unsigned QUIET_CYC     = 3,
  parameter int unsigned PERIOD_CYC    = 80,
  parameter int unsigned LEAD_BITS     = 4,
  parameter int unsigned DATA_BITS     = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 free_run_i,
  input  logic                 start_i,
  input  logic                 sdata_i,
  output logic                 cs_no,
  output logic                 sclk_o,
  output logic [DATA_BITS-1:0] result_o,
  output logic                 valid_o,
  output logic                 frame_err_o
);
  localparam int unsigned FRAME_BITS = LEAD_BITS + DATA_BITS;
  localparam int unsigned BW         = $clog2(FRAME_BITS);
  localparam int unsigned HALF_EFF   = max2(SCLK_HALF_CYC, 1);
  localparam int unsigned SETUP_EFF  = max2(CS_SETUP_CYC, 1);
  localparam int unsigned QUIET_EFF  = max2(QUIET_CYC, 1);
  localparam int unsigned FRAME_MIN  = SETUP_EFF + 2 * FRAME_BITS * HALF_EFF + QUIET_EFF + 1;
  localparam int unsigned PERIOD_EFF = max2(PERIOD_CYC, FRAME_MIN);
  localparam int unsigned CW         = $clog2(max2(SETUP_EFF, QUIET_EFF) + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_EFF - 1);
  localparam logic [CW-1:0] QUIET_LAST = CW'(QUIET_EFF - 1);
  localparam logic [BW-1:0] BIT_LAST   = BW'(FRAME_BITS - 1);

  rd_state_e             state_q;
  logic [CW-1:0]         cnt_q;
  logic [BW-1:0]         bit_q;
  logic                  cs_q;
  logic                  ready;
  logic                  launch;
  logic                  setup_done;
  logic                  sclk_en;
  logic                  last_bit;
  logic                  rise;
  logic                  fall;
  logic [FRAME_BITS-1:0] word;

  assign launch     = (state_q == ST_IDLE) && ready && (free_run_i || start_i);
  assign setup_done = (state_q == ST_SETUP) && (cnt_q == SETUP_LAST);
  assign sclk_en    = (state_q == ST_SHIFT);
  assign last_bit   = (bit_q == BIT_LAST);

  adc_rate_gate #(.PERIOD_CYC(PERIOD_EFF)) u_rate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .ready_o (ready)
  );

  adc_sclk_gen #(.HALF_CYC(HALF_EFF)) u_sclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(setup_done),
    .en_i  (sclk_en),
    .hold_i(last_bit),
    .sclk_o(sclk_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  adc_shift_capture #(.WIDTH(FRAME_BITS)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(rise),
    .sdata_i(sdata_i),
    .word_o (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      bit_q       <= '0;
      cs_q        <= 1'b1;
      result_o    <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (launch) begin
            state_q <= ST_SETUP;
            cs_q    <= 1'b0;
            cnt_q   <= '0;
          end
        end
        ST_SETUP: begin
          if (setup_done) begin
            state_q <= ST_SHIFT;
            bit_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (fall) begin
            if (last_bit) begin
              state_q     <= ST_QUIET;
              cs_q        <= 1'b1;
              cnt_q       <= '0;
              valid_o     <= 1'b1;
              result_o    <= word[DATA_BITS-1:0];
              frame_err_o <= |word[FRAME_BITS-1:DATA_BITS];
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        ST_QUIET: begin
          if (cnt_q == QUIET_LAST) state_q <= ST_IDLE;
          else                     cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no = cs_q;

  p_sclk_idle_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);

  p_setup_clock_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> sclk_o);

  p_valid_on_cs_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(cs_no));

  p_err_with_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> valid_o);

  p_quiet_after_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no);

endmodule

// File: tb/adc_frame_reader_bench.sv
module adc_frame_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int S = 2;
  localparam int H = 2;
  localparam int Q = 3;
  localparam int P = 80;
  localparam int ACTIVE   = S + 32 * H;
  localparam int BUSY_LEN = ACTIVE + Q;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        free_run;
  logic        start;
  logic        sdata;
  logic        cs_n;
  logic        sclk;
  logic [11:0] result;
  logic        valid;
  logic        err;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_frame_reader #(
    .SCLK_HALF_CYC(H),
    .CS_SETUP_CYC (S),
    .QUIET_CYC    (Q),
    .PERIOD_CYC   (P),
    .LEAD_BITS    (4),
    .DATA_BITS    (12)
  ) u_adc_frame_reader (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .free_run_i (free_run),
    .start_i    (start),
    .sdata_i    (sdata),
    .cs_no      (cs_n),
    .sclk_o     (sclk),
    .result_o   (result),
    .valid_o    (valid),
    .frame_err_o(err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [15:0] make_word(input int n);
    case (n % 5)
      0:       return {4'h0, 12'hFFF};
      1:       return {4'h0, 12'h000};
      2:       return {4'h0, 12'hA5C};
      3:       return {4'h8, 12'h35A};
      default: return {4'h1, 12'((n * 97) & 12'hFFF)};
    endcase
  endfunction

  // behavioural converter: first bit on chip-select fall, next bits on sclk falls
  logic [15:0] exp_q[$];
  initial begin
    logic [15:0] cur;
    int bi;
    int nframe;
    cur = '0; bi = 0; nframe = 0;
    sdata = 1'b0;
    forever begin
      @(negedge cs_n or negedge sclk);
      if (cs_n === 1'b0 && sclk === 1'b1) begin
        cur = make_word(nframe);
        nframe++;
        exp_q.push_back(cur);
        bi = 15;
        sdata = cur[15];
      end else if (cs_n === 1'b0 && bi >= 0) begin
        sdata = cur[bi];
        bi--;
      end
    end
  end

  // reference timeline: position within the frame since the launch edge
  bit m_busy;
  int m_k;
  int m_since;
  bit m_launch;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_k = 0; m_since = P - 1;
    end else begin
      m_launch = !m_busy && (m_since == P - 1) && (free_run || start);
      if (m_busy) begin
        m_k++;
        if (m_k == BUSY_LEN) m_busy = 1'b0;
      end else if (m_launch) begin
        m_busy = 1'b1; m_k = 0;
      end
      if (m_launch) m_since = 0;
      else if (m_since < P - 1) m_since++;
    end
  end

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      logic e_cs, e_sclk, e_valid;
      logic [15:0] w;
      e_cs    = !(m_busy && m_k < ACTIVE);
      e_sclk  = (m_busy && m_k >= S && m_k < ACTIVE) ? (((m_k - S) % (2 * H)) >= H) : 1'b1;
      e_valid = m_busy && (m_k == ACTIVE);
      if (m_busy && m_k >= ACTIVE)
        check(cs_n === e_cs, "R7 cs_no quiet", int'(cs_n), int'(e_cs));
      else if (free_run)
        check(cs_n === e_cs, "R8 cs_no free-run", int'(cs_n), int'(e_cs));
      else
        check(cs_n === e_cs, "R9 cs_no single-shot", int'(cs_n), int'(e_cs));
      if (m_busy && m_k < S)
        check(sclk === e_sclk, "R2 sclk_o setup", int'(sclk), int'(e_sclk));
      else
        check(sclk === e_sclk, "R3 sclk_o", int'(sclk), int'(e_sclk));
      check(valid === e_valid, "R5 valid_o", int'(valid), int'(e_valid));
      if (e_valid) begin
        w = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hxxxx;
        check(result === w[11:0], "R4 result_o", int'(result), int'(w[11:0]));
        check(err === (w[15:12] != 4'h0), "R6 frame_err_o", int'(err), int'(w[15:12] != 4'h0));
      end else begin
        check(err === 1'b0, "R6 frame_err_o idle", int'(err), 0);
      end
    end
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; free_run = 1'b0; start = 1'b0;
    repeat (5) @(negedge clk);
    check(cs_n === 1'b1, "R1 cs_no in reset", int'(cs_n), 1);
    check(sclk === 1'b1, "R1 sclk_o in reset", int'(sclk), 1);
    check(valid === 1'b0, "R1 valid_o in reset", int'(valid), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(cs_n === 1'b1, "R1 cs_no idle after reset", int'(cs_n), 1);
    // R8: continuous conversion
    free_run = 1'b1;
    repeat (12 * P) @(negedge clk);
    free_run = 1'b0;
    repeat (150) @(negedge clk);
    // R9: single-shot, including pulses while busy or before the period ends
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    repeat (300) @(negedge clk);
    pulse_start();
    repeat (75) @(negedge clk);
    pulse_start();
    repeat (200) @(negedge clk);
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (300) @(negedge clk);
    free_run = 1'b1;
    repeat (4 * P) @(negedge clk);
    free_run = 1'b0;
    repeat (150) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

endmodule